// File: doc/BRIEF.md
# Burst-Aware DRAM Refresh Scheduler

This block decides when a dynamic memory array must be refreshed and hands each refresh to the access sequencer. A prescaler and a reloadable divider turn the system clock into a steady stream of refresh ticks. The block keeps a count of the refreshes it owes and raises a request whenever that count is non-zero. The sequencer accepts a request by asserting a grant in a cycle where the request is high. Each accepted refresh moves a row pointer on by one. The pointer wraps at a row count chosen by a density code.

Bursts are protected. While the sequencer reports an active burst, the request is held back, so single row refreshes slip behind the burst. The total refresh time is still honoured, because an age monitor times how long a refresh has been pending. Once that wait passes four fifths of the refresh period, the urgent flag rises and the request is presented even in the middle of a burst. The sequencer is then expected to preempt the burst.

Top module: `refresh_sched`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `ref_req` and `ref_urgent` are 0 and `row_addr` is 0.
- R2: A refresh tick occurs every 16*(`div_val`+1) clocks. The first tick falls on the 16th rising edge after reset is released. A tick adds one to the owed count, so `ref_req` is first seen high after that 16th edge when there is no burst.
- R3: The owed count saturates at 7 (2^3-1). A tick that arrives at 7 with no accepted grant is lost, and the count never wraps to 0.
- R4: `ref_req` is 1 exactly when the owed count is non-zero and either `burst_active` is 0 or `ref_urgent` is 1.
- R5: A grant is accepted only in a cycle where `ref_gnt` and `ref_req` are both 1. Each accepted grant removes one owed refresh. A grant without a request has no effect on `row_addr` or on the owed count.
- R6: The pending age is 0 when nothing is owed. It rises by one per clock while something is owed. `ref_urgent` is 1 exactly when something is owed and the age exceeds floor(16*(`div_val`+1)*4/5).
- R7: Each accepted grant advances `row_addr` by one. When `row_addr` is at or above (256<<`size_code`)-1, it returns to 0 instead.
- R8: An accepted grant restarts the pending age at 0, even when further refreshes are still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_val | input | 6 | Refresh divider value; period is 16*(value+1) clocks |
| size_code | input | 2 | Density code; row count is 256<<code |
| burst_active | input | 1 | Sequencer is inside a burst; defers non-urgent refresh |
| ref_gnt | input | 1 | Sequencer accepts the pending refresh |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Pending refresh has waited beyond four fifths of the period |
| row_addr | output | 11 | Row to refresh next |

## Verification
The bench builds the block with its default parameters: a 16-clock prescaler, a 6-bit divider, a 3-bit owed counter and 256 base rows. Small divider values of 0 to 3 give refresh periods of 16 to 64 clocks. This puts owed-count saturation, burst deferral followed by urgent preemption, and a full row wrap at both 256 and 512 rows within a few thousand cycles. Grant patterns include held, alternating and absent grants, and burst patterns include long and toggling bursts, so grants offered without a request also occur.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // Clocks between two refresh ticks for a given divider value.
  function automatic int unsigned period_clocks(input int unsigned prescale,
                                                input int unsigned divider);
    return prescale * (divider + 1);
  endfunction

  // Age beyond which a pending refresh becomes urgent.
  function automatic int unsigned urgent_limit(input int unsigned period,
                                               input int unsigned num,
                                               input int unsigned den);
    return (period * num) / den;
  endfunction

  // Number of rows for a density code.
  function automatic int unsigned row_count(input int unsigned base_log2,
                                            input int unsigned code);
    return 32'd1 << (base_log2 + code);
  endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int PRE_DIV = 16,
  parameter int DIV_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] per_cnt;
  logic             pre_tick;

  assign pre_tick = (pre_cnt == PRE_W'(PRE_DIV - 1));
  assign tick     = pre_tick && (per_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) begin
        per_cnt <= (per_cnt == '0) ? div_val : per_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
  parameter int OWED_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              take,
  output logic [OWED_W-1:0] owed,
  output logic              pending
);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  assign pending = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (owed != OWED_MAX) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/rfs_age_mon.sv
module rfs_age_mon #(
  parameter int AGE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             take,
  input  logic [AGE_W-1:0] limit,
  output logic [AGE_W-1:0] age,
  output logic             urgent
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  assign urgent = pending && (age > limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0;
    end else if (take || !pending) begin
      age <= '0;
    end else if (age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int BASE_LOG2 = 8,
  parameter int SIZE_W    = 2,
  parameter int ROW_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              take,
  output logic [ROW_W-1:0]  row
);
  import refresh_sched_pkg::*;

  logic [ROW_W-1:0] row_last;
  logic             at_end;

  assign row_last = ROW_W'(row_count(BASE_LOG2, int'(size_code)) - 1);
  assign at_end   = (row >= row_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
    end else if (take) begin
      row <= at_end ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int PRE_DIV   = 16,
  parameter int DIV_W     = 6,
  parameter int OWED_W    = 3,
  parameter int SIZE_W    = 2,
  parameter int BASE_LOG2 = 8,
  parameter int URG_NUM   = 4,
  parameter int URG_DEN   = 5,
  parameter int ROW_W     = BASE_LOG2 + (2 ** SIZE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_val,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              burst_active,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic [ROW_W-1:0]  row_addr
);
  import refresh_sched_pkg::*;

  localparam int AGE_W = $clog2(PRE_DIV * (2 ** DIV_W)) + 1;

  // Named internal events, visible to the bound checker.
  logic              tick;
  logic              take;
  logic              pending;
  logic [OWED_W-1:0] owed;
  logic [AGE_W-1:0]  age;
  logic [AGE_W-1:0]  limit;

  assign limit   = AGE_W'(urgent_limit(period_clocks(PRE_DIV, int'(div_val)),
                                       URG_NUM, URG_DEN));
  assign ref_req = pending && (!burst_active || ref_urgent);
  assign take    = ref_gnt && ref_req;

  rfs_tick_gen #(.PRE_DIV(PRE_DIV), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick)
  );

  rfs_owed_ctr #(.OWED_W(OWED_W)) u_owed (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take),
    .owed(owed), .pending(pending)
  );

  rfs_age_mon #(.AGE_W(AGE_W)) u_age (
    .clk(clk), .rst_n(rst_n), .pending(pending), .take(take),
    .limit(limit), .age(age), .urgent(ref_urgent)
  );

  rfs_row_ctr #(.BASE_LOG2(BASE_LOG2), .SIZE_W(SIZE_W), .ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .size_code(size_code), .take(take), .row(row_addr)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int OWED_W = 3,
  parameter int AGE_W  = 11,
  parameter int ROW_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_active,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic [ROW_W-1:0]  row_addr,
  input logic              tick,
  input logic              take,
  input logic              pending,
  input logic [OWED_W-1:0] owed,
  input logic [AGE_W-1:0]  age
);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  // R4: no refresh request inside a burst unless urgent
  p_defer_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !ref_urgent) |-> !ref_req);

  // R6: urgency only while a refresh is owed
  p_urgent_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> pending);

  // R3: saturated count absorbs a tick without wrapping
  p_owed_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == OWED_MAX && tick && !take) |=> (owed == OWED_MAX));

  // R5: no accepted grant leaves the row pointer alone
  p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(row_addr));

  // R7: an accepted grant moves the row pointer by one or wraps to zero
  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (row_addr == $past(row_addr) + 1'b1 || row_addr == '0));

  // R8: an accepted grant restarts the pending age
  p_age_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (age == '0));

  // R5: an accepted grant without a new tick lowers the owed count
  p_owed_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tick) |=> (owed == $past(owed) - 1'b1));
endmodule

bind refresh_sched refresh_sched_chk #(
  .OWED_W(OWED_W), .AGE_W(AGE_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_active(burst_active),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .row_addr(row_addr),
  .tick(tick), .take(take), .pending(pending), .owed(owed), .age(age)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  div_val = '0;
  logic [1:0]  size_code = '0;
  logic        burst_active = 1'b0;
  logic        ref_gnt = 1'b0;
  logic        ref_req;
  logic        ref_urgent;
  logic [10:0] row_addr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference state
  int m_pre = 0, m_per = 0, m_owed = 0, m_age = 0, m_row = 0;

  always #2 clk = ~clk;

  refresh_sched u_dut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .size_code(size_code),
    .burst_active(burst_active), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .row_addr(row_addr)
  );

  function automatic int lim_now();
    return (16 * (int'(div_val) + 1) * 4) / 5;
  endfunction
  function automatic bit m_urgent();
    return (m_owed != 0) && (m_age > lim_now());
  endfunction
  function automatic bit m_req();
    return (m_owed != 0) && (!burst_active || m_urgent());
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Reference update on each clock
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pre = 0; m_per = 0; m_owed = 0; m_age = 0; m_row = 0;
    end else begin
      bit t, acc;
      int rows;
      t = (m_pre == 15) && (m_per == 0);
      acc = ref_gnt && m_req();
      rows = 256 << size_code;
      if (acc || m_owed == 0) m_age = 0;
      else if (m_age < 2047) m_age = m_age + 1;
      if (acc) m_row = (m_row >= rows - 1) ? 0 : m_row + 1;
      m_owed = m_owed + (t ? 1 : 0) - (acc ? 1 : 0);
      if (m_owed > 7) m_owed = 7;
      if (m_pre == 15) begin
        m_per = (m_per == 0) ? int'(div_val) : m_per - 1;
        m_pre = 0;
      end else m_pre = m_pre + 1;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2/R3/R4/R5 ref_req", ref_req, m_req());
      check("R6/R8 ref_urgent", ref_urgent, m_urgent());
      check("R5/R7 row_addr", row_addr, m_row);
    end
  end

  // Watchdog
  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int wait_cyc;
    run(3);
    #1;
    check("R1 ref_req in reset", ref_req, 0);
    check("R1 ref_urgent in reset", ref_urgent, 0);
    check("R1 row_addr in reset", row_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 ref_req after release", ref_req, 0);
    check("R1 row_addr after release", row_addr, 0);
    // R2: first request after the 16th edge
    wait_cyc = 1;
    while (!ref_req && wait_cyc < 40) begin
      @(negedge clk); #1;
      wait_cyc++;
    end
    check("R2 first tick edge", wait_cyc, 16);
    // R3: saturate the owed count, then drain with a held grant
    run(200);
    ref_gnt = 1'b1;
    run(40);
    ref_gnt = 1'b0;
    // R5: alternating grant
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      ref_gnt = ~ref_gnt;
    end
    ref_gnt = 1'b0;
    // R4/R6: long burst forces urgent preemption
    @(negedge clk);
    div_val = 6'd3;
    burst_active = 1'b1;
    ref_gnt = 1'b1;
    run(600);
    ref_gnt = 1'b0;
    run(300);
    ref_gnt = 1'b1;
    run(200);
    burst_active = 1'b0;
    // R7: row wrap at 256 rows
    div_val = 6'd0;
    run(4400);
    check("R7 row wrapped at 256", (row_addr < 11'd256) ? 1 : 0, 1);
    // R7: larger density
    size_code = 2'd1;
    run(9000);
    // R4/R8: toggling burst
    div_val = 6'd2;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (i % 7 == 0) burst_active = ~burst_active;
      ref_gnt = (i % 3 != 0);
    end
    burst_active = 1'b0;
    ref_gnt = 1'b0;
    run(50);
    // R5: grant with nothing owed after a drain
    ref_gnt = 1'b1;
    run(30);
    ref_gnt = 1'b0;
    run(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule